// File: doc/BRIEF.md
# SDRAM Write-Burst Interrupt Sequencer

This block turns a simple request stream into SDRAM command-pin activity. It issues fixed four-beat write bursts and lets a later request cut a burst short: a new WRITE takes over the data bus at once, a READ ends the write and releases the bus, and a PRECHARGE truncates the write and then waits out the write-recovery time before it reaches the pins. While it waits, the byte masks are held high so that no stray beat is written. It also spaces an ACTIVATE after a PRECHARGE of the same bank, and a WRITE after a READ, so that the data bus is not driven by both sides at once.

A request is taken on a cycle in which `req_valid_i` and `req_ready_o` are both high, and its command appears on the pins in the following cycle. Every pin is driven from a register. Write recovery and row-precharge times are given in picoseconds together with the clock period, and the block rounds each up to whole clocks when it is elaborated. On idle cycles the block drives a NOP.

Top module: `sdram_wr_intr_seq`

## Requirements
- R1: During and right after reset the pins carry a NOP, `sd_dq_oe_o` is low and every `sd_dqm_o` bit is low.
- R2: A request accepted in cycle t shows on the pins in cycle t+1. Request codes: 0 = WRITE, 1 = READ, 2 = PRECHARGE, 3 = ACTIVATE. Pin patterns {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010.
- R3: A WRITE puts beat 0 (bits [DQ_W-1:0] of `req_wdata_i`) on DQ in the WRITE cycle, then beats 1, 2 and 3 in the next three cycles, with `sd_dq_oe_o` high and masks low; an unbroken burst leaves `sd_dq_oe_o` low in the fifth cycle.
- R4: A WRITE may be accepted in any cycle after a previous WRITE; its beat 0 shares the cycle of the new command, and no further beat of the old burst is driven.
- R5: A READ accepted in cycle t keeps only old write beats driven up to cycle t; from the READ cycle t+1 on, `sd_dq_oe_o` is low.
- R6: After a READ on the pins in cycle R, a WRITE is not accepted before cycle R+CAS_LAT+4-1, so the WRITE reaches the pins no earlier than R+CAS_LAT+4.
- R7: A PRECHARGE accepted in cycle t keeps the write beats driven up to cycle t (last one in cycle L) and reaches the pins in cycle max(t+1, L+m), with m = tWR / tCK rounded up.
- R8: All mask bits are high from cycle t+1 through the PRECHARGE cycle of R7, and `sd_dq_oe_o` is low in those cycles.
- R9: While a truncating PRECHARGE waits for write recovery, `req_ready_o` stays low.
- R10: An ACTIVATE to a bank reaches the pins no sooner than tRP / tCK (rounded up) cycles after a PRECHARGE of that bank; other banks are not held back.
- R11: Bank and address travel with their command; a PRECHARGE drives address zero (single bank).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_op_i | input | 2 | Request code (R2) |
| req_bank_i | input | BA_W | Target bank |
| req_addr_i | input | A_W | Row for ACTIVATE, column for READ/WRITE |
| req_wdata_i | input | BURST_LEN*DQ_W | Write beats, beat i at bits [i*DQ_W +: DQ_W] |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank select |
| sd_addr_o | output | A_W | Address |
| sd_dq_o | output | DQ_W | Write data |
| sd_dq_oe_o | output | 1 | Data bus output enable |
| sd_dqm_o | output | DQ_W/8 | Byte masks, high masks |

## Verification
A wrong beat count or a missed abort shows as `sd_dq_oe_o` staying high one or more cycles past the point where a READ or PRECHARGE cut the burst, visible in the very next cycle. A recovery counter that is off by one moves the PRECHARGE pattern one cycle early or late and shortens or stretches the mask window by that same cycle, so each offset in the sweep pins it to an exact cycle number. A stale bank timer or read-gap timer shows as `req_ready_o` rising one cycle too early or too late under a held request.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } cmd_e;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_PRE = 2'd2,
    OP_ACT = 2'd3
  } op_e;

  function automatic int clk_ceil(input int t_ps, input int tck_ps);
    int c;
    c = (t_ps + tck_ps - 1) / tck_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdram_seq_dcnt.sv
// Loadable saturating down-counter; done_o when count <= THRESH.
module sdram_seq_dcnt #(
  parameter int LOADV  = 2,
  parameter int THRESH = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int W = $clog2(LOADV + 2);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= W'(LOADV);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q <= W'(THRESH));

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o); // R10

endmodule

// File: rtl/sdram_seq_beats.sv
// Holds the not-yet-driven beats of the current write burst.
module sdram_seq_beats #(
  parameter int DQ_W      = 16,
  parameter int BURST_LEN = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            abort_i,
  input  logic [(BURST_LEN-1)*DQ_W-1:0]   data_i,
  output logic                            more_o,
  output logic [DQ_W-1:0]                 next_o
);
  localparam int CW = $clog2(BURST_LEN);

  logic [CW-1:0]   cnt_q;
  logic [DQ_W-1:0] rem_q [BURST_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < BURST_LEN - 1; i++) rem_q[i] <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(BURST_LEN - 1);
      for (int i = 0; i < BURST_LEN - 1; i++) rem_q[i] <= data_i[i*DQ_W +: DQ_W];
    end else if (abort_i) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      for (int i = 0; i < BURST_LEN - 2; i++) rem_q[i] <= rem_q[i+1];
    end
  end

  assign more_o = (cnt_q != '0);
  assign next_o = rem_q[0];

  AST_ABORT_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i && !start_i |=> !more_o); // R5

endmodule

// File: rtl/sdram_seq_cmd_enc.sv
module sdram_seq_cmd_enc
  import sdram_seq_pkg::*;
(
  input  cmd_e cmd_i,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  always_comb begin
    cs_n_o = 1'b0;
    unique case (cmd_i)
      CMD_ACT: {ras_n_o, cas_n_o, we_n_o} = 3'b011;
      CMD_RD:  {ras_n_o, cas_n_o, we_n_o} = 3'b101;
      CMD_WR:  {ras_n_o, cas_n_o, we_n_o} = 3'b100;
      CMD_PRE: {ras_n_o, cas_n_o, we_n_o} = 3'b010;
      default: {ras_n_o, cas_n_o, we_n_o} = 3'b111;
    endcase
  end
endmodule

// File: rtl/sdram_wr_intr_seq.sv
module sdram_wr_intr_seq
  import sdram_seq_pkg::*;
#(
  parameter int DQ_W      = 16,
  parameter int BA_W      = 2,
  parameter int A_W       = 12,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int TCK_PS    = 10000,
  parameter int TWR_PS    = 25000,
  parameter int TRP_PS    = 18000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [1:0]                  req_op_i,
  input  logic [BA_W-1:0]             req_bank_i,
  input  logic [A_W-1:0]              req_addr_i,
  input  logic [BURST_LEN*DQ_W-1:0]   req_wdata_i,
  output logic                        sd_cs_n_o,
  output logic                        sd_ras_n_o,
  output logic                        sd_cas_n_o,
  output logic                        sd_we_n_o,
  output logic [BA_W-1:0]             sd_ba_o,
  output logic [A_W-1:0]              sd_addr_o,
  output logic [DQ_W-1:0]             sd_dq_o,
  output logic                        sd_dq_oe_o,
  output logic [DQ_W/8-1:0]           sd_dqm_o
);
  localparam int  DM_W      = DQ_W / 8;
  localparam int  NBANK     = 1 << BA_W;
  localparam int  TWR_CYC   = clk_ceil(TWR_PS, TCK_PS);
  localparam int  TRP_CYC   = clk_ceil(TRP_PS, TCK_PS);
  localparam int  RD_GAP    = CAS_LAT + BURST_LEN;
  localparam bit  TWR_IMMED = (TWR_CYC == 1);

  if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_cl
    $error("CAS_LAT must be 2 or 3");
  end
  if (BURST_LEN < 2) begin : g_bad_bl
    $error("BURST_LEN must be at least 2");
  end

  op_e op;
  assign op = op_e'(req_op_i);

  // pin registers
  cmd_e              cmd_q, cmd_n;
  logic [BA_W-1:0]   ba_q, ba_n;
  logic [A_W-1:0]    addr_q, addr_n;
  logic [DQ_W-1:0]   dq_q, dq_n;
  logic              dq_oe_q, dq_oe_n;
  logic              dqm_q, dqm_n;
  // sequencing state
  logic              pre_pend_q, pre_pend_n;
  logic [BA_W-1:0]   pre_bank_q, pre_bank_n;

  logic              beat_start, beat_abort, beat_more;
  logic [DQ_W-1:0]   beat_next;
  logic              twr_done, rd_done, pre_ok, issue_pre, acc;
  logic [BA_W-1:0]   issue_bank;
  logic [NBANK-1:0]  trp_done;

  // write recovery measured from each beat on the pins
  sdram_seq_dcnt #(.LOADV(TWR_CYC - 1), .THRESH(1)) u_twr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (dq_oe_q),
    .done_o (twr_done)
  );

  sdram_seq_dcnt #(.LOADV(RD_GAP - 1), .THRESH(0)) u_rdgap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc && op == OP_RD && !pre_pend_q),
    .done_o (rd_done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_trp
    sdram_seq_dcnt #(.LOADV(TRP_CYC - 1), .THRESH(0)) u_trp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (issue_pre && issue_bank == BA_W'(b)),
      .done_o (trp_done[b])
    );
  end

  sdram_seq_beats #(.DQ_W(DQ_W), .BURST_LEN(BURST_LEN)) u_beats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (beat_start),
    .abort_i (beat_abort),
    .data_i  (req_wdata_i[BURST_LEN*DQ_W-1:DQ_W]),
    .more_o  (beat_more),
    .next_o  (beat_next)
  );

  // a beat on the pins now still needs the full recovery
  assign pre_ok = dq_oe_q ? TWR_IMMED : twr_done;

  always_comb begin
    if (pre_pend_q) begin
      req_ready_o = 1'b0;
    end else begin
      unique case (op)
        OP_WR:   req_ready_o = rd_done;
        OP_ACT:  req_ready_o = trp_done[req_bank_i];
        default: req_ready_o = 1'b1;
      endcase
    end
  end

  assign acc = req_valid_i && req_ready_o;

  always_comb begin
    cmd_n      = CMD_NOP;
    ba_n       = '0;
    addr_n     = '0;
    dqm_n      = 1'b0;
    beat_start = 1'b0;
    beat_abort = 1'b0;
    issue_pre  = 1'b0;
    issue_bank = req_bank_i;
    pre_pend_n = pre_pend_q;
    pre_bank_n = pre_bank_q;
    if (pre_pend_q) begin
      dqm_n      = 1'b1;
      issue_bank = pre_bank_q;
      if (pre_ok) begin
        cmd_n      = CMD_PRE;
        ba_n       = pre_bank_q;
        issue_pre  = 1'b1;
        pre_pend_n = 1'b0;
      end
    end else if (acc) begin
      unique case (op)
        OP_WR: begin
          cmd_n      = CMD_WR;
          ba_n       = req_bank_i;
          addr_n     = req_addr_i;
          beat_start = 1'b1;
        end
        OP_RD: begin
          cmd_n      = CMD_RD;
          ba_n       = req_bank_i;
          addr_n     = req_addr_i;
          beat_abort = 1'b1;
        end
        OP_PRE: begin
          beat_abort = 1'b1;
          dqm_n      = 1'b1;
          if (pre_ok) begin
            cmd_n     = CMD_PRE;
            ba_n      = req_bank_i;
            issue_pre = 1'b1;
          end else begin
            pre_pend_n = 1'b1;
            pre_bank_n = req_bank_i;
          end
        end
        default: begin
          cmd_n  = CMD_ACT;
          ba_n   = req_bank_i;
          addr_n = req_addr_i;
        end
      endcase
    end
  end

  always_comb begin
    dq_oe_n = beat_start || (beat_more && !beat_abort);
    if (beat_start)   dq_n = req_wdata_i[DQ_W-1:0];
    else if (dq_oe_n) dq_n = beat_next;
    else              dq_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= CMD_NOP;
      ba_q       <= '0;
      addr_q     <= '0;
      dq_q       <= '0;
      dq_oe_q    <= 1'b0;
      dqm_q      <= 1'b0;
      pre_pend_q <= 1'b0;
      pre_bank_q <= '0;
    end else begin
      cmd_q      <= cmd_n;
      ba_q       <= ba_n;
      addr_q     <= addr_n;
      dq_q       <= dq_n;
      dq_oe_q    <= dq_oe_n;
      dqm_q      <= dqm_n;
      pre_pend_q <= pre_pend_n;
      pre_bank_q <= pre_bank_n;
    end
  end

  sdram_seq_cmd_enc u_enc (
    .cmd_i   (cmd_q),
    .cs_n_o  (sd_cs_n_o),
    .ras_n_o (sd_ras_n_o),
    .cas_n_o (sd_cas_n_o),
    .we_n_o  (sd_we_n_o)
  );

  assign sd_ba_o    = ba_q;
  assign sd_addr_o  = addr_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = dq_oe_q;
  assign sd_dqm_o   = {DM_W{dqm_q}};

  // elapsed-cycle trackers for the timing assertions
  logic [15:0] since_beat_q, since_rd_q;
  logic [15:0] since_pre_q [NBANK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_beat_q <= '1;
      since_rd_q   <= '1;
      for (int b = 0; b < NBANK; b++) since_pre_q[b] <= '1;
    end else begin
      since_beat_q <= dq_oe_q ? 16'd1 : ((&since_beat_q) ? since_beat_q : since_beat_q + 16'd1);
      since_rd_q   <= (cmd_q == CMD_RD) ? 16'd1 : ((&since_rd_q) ? since_rd_q : since_rd_q + 16'd1);
      for (int b = 0; b < NBANK; b++) begin
        if (cmd_q == CMD_PRE && ba_q == BA_W'(b)) since_pre_q[b] <= 16'd1;
        else if (!(&since_pre_q[b]))              since_pre_q[b] <= since_pre_q[b] + 16'd1;
      end
    end
  end

  AST_PRE_AFTER_TWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_PRE |-> since_beat_q >= 16'(TWR_CYC)); // R7
  AST_ACT_AFTER_TRP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_ACT |-> since_pre_q[ba_q] >= 16'(TRP_CYC)); // R10
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_WR |-> since_rd_q >= 16'(RD_GAP)); // R6
  AST_RD_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_RD |-> !sd_dq_oe_o); // R5
  AST_WR_BEAT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_WR |-> sd_dq_oe_o && sd_dqm_o == '0); // R3
  AST_MASK_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_q |-> !dq_oe_q); // R8
  AST_PEND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_pend_q |=> cmd_q == CMD_NOP || cmd_q == CMD_PRE); // R9

endmodule

// File: tb/sdram_wr_intr_seq_bench.sv
module sdram_wr_intr_seq_bench;
  localparam int DQ_W = 16, BA_W = 2, A_W = 12, BL = 4, CL = 2;
  localparam int TCK_PS = 10000, TWR_PS = 25000, TRP_PS = 18000;
  localparam int TWR_CYC = (TWR_PS + TCK_PS - 1) / TCK_PS;
  localparam int TRP_CYC = (TRP_PS + TCK_PS - 1) / TCK_PS;
  localparam int RD_GAP  = CL + BL;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [BA_W-1:0] req_bank;
  logic [A_W-1:0] req_addr;
  logic [BL*DQ_W-1:0] req_wdata;
  logic cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [BA_W-1:0] ba;
  logic [A_W-1:0] addr;
  logic [DQ_W-1:0] dq;
  logic [DQ_W/8-1:0] dqm;
  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  sdram_wr_intr_seq #(
    .DQ_W(DQ_W), .BA_W(BA_W), .A_W(A_W), .BURST_LEN(BL), .CAS_LAT(CL),
    .TCK_PS(TCK_PS), .TWR_PS(TWR_PS), .TRP_PS(TRP_PS)
  ) u_sdram_wr_intr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr), .sd_dq_o(dq), .sd_dq_oe_o(dq_oe), .sd_dqm_o(dqm)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [BA_W-1:0] b,
                       input logic [A_W-1:0] a, input logic [BL*DQ_W-1:0] wd);
    req_valid = v; req_op = op; req_bank = b; req_addr = a; req_wdata = wd;
  endtask

  function automatic logic [BL*DQ_W-1:0] mk_data(input logic [7:0] tag);
    logic [BL*DQ_W-1:0] d;
    for (int i = 0; i < BL; i++) d[i*DQ_W +: DQ_W] = {tag, 8'(i)};
    return d;
  endfunction

  task automatic idle(input int n);
    drive(1'b0, 2'd0, '0, '0, '0);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 WRITE, 1 READ, 2 PRECHARGE interrupting a write accepted at cycle 0
  task automatic run_intr(input int kind, input int k);
    logic [BL*DQ_W-1:0] da, db;
    logic [A_W-1:0] acol, bcol;
    logic [3:0] ecmd;
    logic eoe;
    logic [DQ_W-1:0] edq;
    string tag;
    int last, pc;
    da = mk_data(8'hA0 + 8'(k)); db = mk_data(8'hB0 + 8'(k));
    acol = A_W'(16 * k + kind); bcol = A_W'(12'h0C0 + k);
    last = (k < BL) ? k : BL;
    pc = (k + 1 > last + TWR_CYC) ? k + 1 : last + TWR_CYC;
    tag = (kind == 0) ? "R4" : (kind == 1) ? "R5" : "R7";
    drive(1'b1, 2'd0, 2'd1, acol, da);
    #1 chk("R3", "ready for write", 32'(req_ready), 32'd1);
    for (int c = 1; c <= k + BL + 3; c++) begin
      @(negedge clk);
      ecmd = P_NOP;
      if (c == 1) ecmd = P_WR;
      if (c == k + 1 && kind == 0) ecmd = P_WR;
      if (c == k + 1 && kind == 1) ecmd = P_RD;
      if (c == pc && kind == 2) ecmd = P_PRE;
      eoe = (c <= last) || (kind == 0 && c >= k + 1 && c <= k + BL);
      edq = (c <= last) ? da[(c-1)*DQ_W +: DQ_W] : db[(c-k-1)*DQ_W +: DQ_W];
      chk((c == 1) ? "R2" : tag, "cmd", 32'(pins), 32'(ecmd));
      chk((kind == 2 && c > k) ? "R8" : tag, "dq_oe", 32'(dq_oe), 32'(eoe));
      if (eoe) chk((c <= last) ? "R3" : "R4", "dq", 32'(dq), 32'(edq));
      chk("R8", "dqm", 32'(dqm), (kind == 2 && c >= k + 1 && c <= pc) ? 32'h3 : 32'h0);
      if (c == 1) begin
        chk("R11", "ba", 32'(ba), 32'd1);
        chk("R11", "addr", 32'(addr), 32'(acol));
      end
      if ((kind != 2 && c == k + 1) || (kind == 2 && c == pc)) begin
        chk("R11", "ba", 32'(ba), 32'd2);
        chk("R11", "addr", 32'(addr), (kind == 2) ? 32'd0 : 32'(bcol));
      end
      if (c == k) begin
        drive(1'b1, 2'(kind), 2'd2, bcol, db);
        #1 chk(tag, "ready for interrupt", 32'(req_ready), 32'd1);
      end else if (kind == 2 && c > k && c < pc) begin
        drive(1'b1, 2'd1, 2'd0, '0, '0);
        #1 chk("R9", "ready while pending", 32'(req_ready), 32'd0);
      end else begin
        drive(1'b0, 2'd0, '0, '0, '0);
      end
    end
    idle(10);
  endtask

  task automatic run_rd_gap();
    logic [BL*DQ_W-1:0] d;
    int got;
    d = mk_data(8'hC5);
    got = 0;
    drive(1'b1, 2'd1, 2'd0, 12'h033, '0);
    @(negedge clk);
    chk("R2", "read cmd", 32'(pins), 32'(P_RD));
    chk("R11", "read addr", 32'(addr), 32'h033);
    for (int c = 1; c <= RD_GAP && got == 0; c++) begin
      drive(1'b1, 2'd0, 2'd3, 12'h044, d);
      #1 chk("R6", "write ready after read", 32'(req_ready), 32'(c >= RD_GAP));
      if (req_ready) got = 1;
      @(negedge clk);
    end
    chk("R6", "write cmd after gap", 32'(pins), 32'(P_WR));
    chk("R3", "beat0 after gap", 32'(dq), 32'(d[DQ_W-1:0]));
    idle(10);
  endtask

  task automatic run_trp();
    int got;
    got = 0;
    drive(1'b1, 2'd2, 2'd1, 12'hFFF, '0);
    @(negedge clk);
    chk("R10", "pre cmd", 32'(pins), 32'(P_PRE));
    chk("R11", "pre addr zero", 32'(addr), 32'd0);
    chk("R8", "dqm on idle pre", 32'(dqm), 32'h3);
    for (int c = 1; c <= TRP_CYC + 1 && got == 0; c++) begin
      drive(1'b1, 2'd3, 2'd1, 12'h155, '0);
      #1 chk("R10", "act ready same bank", 32'(req_ready), 32'(c >= TRP_CYC));
      if (req_ready) got = 1;
      @(negedge clk);
    end
    chk("R2", "act cmd", 32'(pins), 32'(P_ACT));
    chk("R11", "act row", 32'(addr), 32'h155);
    chk("R11", "act bank", 32'(ba), 32'd1);
    idle(4);
    drive(1'b1, 2'd2, 2'd3, '0, '0);
    @(negedge clk);
    drive(1'b1, 2'd3, 2'd0, 12'h2AA, '0);
    #1 chk("R10", "act ready other bank", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R10", "act other bank cmd", 32'(pins), 32'(P_ACT));
    idle(4);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(1'b0, 2'd0, '0, '0, '0);
    repeat (3) @(negedge clk);
    chk("R1", "cmd in reset", 32'(pins), 32'(P_NOP));
    chk("R1", "oe in reset", 32'(dq_oe), 32'd0);
    chk("R1", "dqm in reset", 32'(dqm), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmd after reset", 32'(pins), 32'(P_NOP));
    chk("R1", "oe after reset", 32'(dq_oe), 32'd0);
    chk("R1", "dqm after reset", 32'(dqm), 32'd0);
    idle(2);
    for (int kind = 0; kind < 3; kind++)
      for (int k = 1; k <= BL + 1; k++)
        run_intr(kind, k);
    run_rd_gap();
    run_trp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule